// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a register-transfer engine. It holds eight general registers of parameterised width, two read ports and one write port, and a function unit. The function unit combines an adder-based arithmetic and logic unit with a one-position shifter. A single 16-bit control word, presented for one clock cycle, names the two source registers, the destination, the Bus B source, the function and the write-back source. The word also decides whether the destination is written at the next rising edge. Taken together, one control word makes one micro-operation.

Bus A goes out as an address output and Bus B as a data output. The V, C, N and Z flags describe the function-unit result of the current cycle. The block has no handshake. A control word is consumed on every clock, so the block never applies back-pressure. Whatever sequences the control words must hold each word stable for one full cycle.

Top module: `cw_datapath`

## Requirements
- R1: The control word is split, from bit 15 down, into destination select [15:13], Bus A select [12:10], Bus B register select [9:7], constant select [6], function code [5:2], external write-back select [1] and write enable [0].
- R2: `addr_out` shows the register named by [12:10]. `data_out` shows the register named by [9:7] when bit 6 is 0, and `const_in` when bit 6 is 1.
- R3: When bit 0 is 1, the register named by [15:13] takes the write-back value at the rising clock edge.
- R4: When bit 0 is 0, no register changes, whatever the other fields hold.
- R5: Bit 1 = 0 writes back the function-unit result. Bit 1 = 1 writes back `data_in`.
- R6: Each arithmetic code computes A + Y + cin. The codes are: 0000 A, 0001 A+1, 0010 A+B, 0011 A+~B, 0100 A+~B+1, 0101 A+B+1, 0110 A-1 (Y all ones, cin 0), and 0111 A (Y all ones, cin 1). For these codes C is the carry out of the adder. V is set when A and Y share a sign and the sum's sign differs from it.
- R7: The logic codes are 1000 AND, 1001 OR, 1010 XOR and 1011 NOT A. For these codes C and V are 0.
- R8: The codes with bits [3:2] = 11 select the shifter, which acts on Bus B: 1100 passes B, 1101 shifts right by one, 1110 shifts left by one, and 1111 passes B. Vacated bits fill with 0, and C and V are 0.
- R9: N is the most significant bit of the function-unit result. Z is 1 exactly when that result is zero. Both follow the result even when bit 1 selects `data_in`.
- R10: A synchronous reset clears all eight registers to zero.
- R11: A register that is both read and written in one cycle shows its old value until the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 16 | Micro-operation control word |
| const_in | input | DW | Constant that may drive Bus B |
| data_in | input | DW | External write-back data |
| addr_out | output | DW | Bus A |
| data_out | output | DW | Bus B |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result is zero |

## Verification
The assertions assume that `ctrl_word`, `const_in` and `data_in` are fully driven, with no unknown bits. They also assume these inputs change only between clock edges and stay constant across each sampling edge. The stimulus keeps to this by driving every input at the falling edge and always giving all sixteen control bits a defined value. It holds reset through at least one rising edge before any checked micro-operation.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
  localparam int AW   = 3;
  localparam int NREG = 1 << AW;
  localparam int CW_W = 16;

  typedef struct packed {
    logic [AW-1:0] dst;
    logic [AW-1:0] srca;
    logic [AW-1:0] srcb;
    logic          bsel_const;
    logic [3:0]    fsel;
    logic          wsel_ext;
    logic          wr_en;
  } cword_t;

  localparam logic [1:0] GRP_SHIFT = 2'b11;
  localparam logic [3:0] FS_ADD    = 4'b0010;
  localparam logic [3:0] FS_SHL    = 4'b1110;
endpackage

// File: rtl/cwdp_regbank.sv
module cwdp_regbank #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0][DW-1:0] mem;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  mem[g] <= '0;
      else if (we && (waddr == AW'(g)))         mem[g] <= wdata;
    end
  end

  // Combinational reads: a same-cycle write is seen only after the edge.
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R3: the written value lands in the addressed register
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));

  // R4: without a write enable the whole file holds
  a_r4_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mem));
endmodule

// File: rtl/cwdp_alu.sv
module cwdp_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    fs,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          ovf
);
  logic [DW-1:0] y;
  logic          cin;
  logic [DW:0]   sum;
  logic [DW-1:0] lres;

  always_comb begin
    unique case (fs[2:0])
      3'b000:  begin y = '0; cin = 1'b0; end
      3'b001:  begin y = '0; cin = 1'b1; end
      3'b010:  begin y = b;  cin = 1'b0; end
      3'b011:  begin y = ~b; cin = 1'b0; end
      3'b100:  begin y = ~b; cin = 1'b1; end
      3'b101:  begin y = b;  cin = 1'b1; end
      3'b110:  begin y = '1; cin = 1'b0; end
      default: begin y = '1; cin = 1'b1; end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + {{DW{1'b0}}, cin};

  always_comb begin
    unique case (fs[1:0])
      2'b00:   lres = a & b;
      2'b01:   lres = a | b;
      2'b10:   lres = a ^ b;
      default: lres = ~a;
    endcase
  end

  assign res  = fs[3] ? lres : sum[DW-1:0];
  assign cout = !fs[3] && sum[DW];
  assign ovf  = !fs[3] && (a[DW-1] == y[DW-1]) && (sum[DW-1] != a[DW-1]);
endmodule

// File: rtl/cwdp_shifter.sv
module cwdp_shifter #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] b,
  input  logic [1:0]    mode,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (mode)
      2'b01:   res = {1'b0, b[DW-1:1]};
      2'b10:   res = {b[DW-2:0], 1'b0};
      default: res = b;
    endcase
  end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cwdp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [DW-1:0]   const_in,
  input  logic [DW-1:0]   data_in,
  output logic [DW-1:0]   addr_out,
  output logic [DW-1:0]   data_out,
  output logic            flag_v,
  output logic            flag_c,
  output logic            flag_n,
  output logic            flag_z
);
  cword_t        cw;
  logic [DW-1:0] bus_a, reg_b, bus_b;
  logic [DW-1:0] alu_res, sh_res, fu_res, wb_data;
  logic          alu_c, alu_v, pick_shift;

  assign cw = cword_t'(ctrl_word);

  cwdp_regbank #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .rst(rst), .we(cw.wr_en), .waddr(cw.dst), .wdata(wb_data),
    .raddr_a(cw.srca), .raddr_b(cw.srcb), .rdata_a(bus_a), .rdata_b(reg_b)
  );

  assign bus_b = cw.bsel_const ? const_in : reg_b;

  cwdp_alu #(.DW(DW)) u_alu (
    .a(bus_a), .b(bus_b), .fs(cw.fsel),
    .res(alu_res), .cout(alu_c), .ovf(alu_v)
  );

  cwdp_shifter #(.DW(DW)) u_sh (
    .b(bus_b), .mode(cw.fsel[1:0]), .res(sh_res)
  );

  assign pick_shift = (cw.fsel[3:2] == GRP_SHIFT);
  assign fu_res     = pick_shift ? sh_res : alu_res;
  assign wb_data    = cw.wsel_ext ? data_in : fu_res;

  assign addr_out = bus_a;
  assign data_out = bus_b;
  assign flag_c   = !pick_shift && alu_c;
  assign flag_v   = !pick_shift && alu_v;
  assign flag_n   = fu_res[DW-1];
  assign flag_z   = (fu_res == '0);

  // R6: plain add agrees with the Bus A and Bus B values and carry
  a_r6_add_matches_buses: assert property (@(posedge clk) disable iff (rst)
    (cw.fsel == FS_ADD) |-> ({flag_c, fu_res} == ({1'b0, addr_out} + {1'b0, data_out})));

  // R7: logic codes never raise carry or overflow
  a_r7_logic_no_cv: assert property (@(posedge clk) disable iff (rst)
    (cw.fsel[3:2] == 2'b10) |-> (!flag_c && !flag_v));

  // R8: left shift result is Bus B moved up one with zero fill
  a_r8_shl_from_busb: assert property (@(posedge clk) disable iff (rst)
    (cw.fsel == FS_SHL) |-> (fu_res == {data_out[DW-2:0], 1'b0} && !flag_c && !flag_v));
endmodule

// File: tb/sim_cw_datapath.sv
`timescale 1ns/1ps
module sim_cw_datapath;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   ctrl = '0;
  logic [DW-1:0] kin = '0, din = '0;
  logic [DW-1:0] addr_out, data_out;
  logic          fv, fc, fn, fz;

  always #10 clk = ~clk;

  cw_datapath #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl), .const_in(kin), .data_in(din),
    .addr_out(addr_out), .data_out(data_out),
    .flag_v(fv), .flag_c(fc), .flag_n(fn), .flag_z(fz)
  );

  typedef struct {
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [3:0]    vcnz;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] model [8];
  int            checks = 0, errors = 0;
  bit            done = 0;

  function automatic logic [15:0] mk(int d, int a, int b, bit mb, logic [3:0] fs, bit md, bit rw);
    return {3'(d), 3'(a), 3'(b), mb, fs, md, rw};
  endfunction

  // returns {v, c, result}
  function automatic logic [DW+1:0] model_fu(logic [3:0] fs, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] y, r;
    logic          ci, v, c;
    logic [DW:0]   s;
    v = 0; c = 0; r = '0;
    if (!fs[3]) begin
      case (fs[2:0])
        3'd0: begin y = 0;  ci = 0; end
        3'd1: begin y = 0;  ci = 1; end
        3'd2: begin y = b;  ci = 0; end
        3'd3: begin y = ~b; ci = 0; end
        3'd4: begin y = ~b; ci = 1; end
        3'd5: begin y = b;  ci = 1; end
        3'd6: begin y = '1; ci = 0; end
        default: begin y = '1; ci = 1; end
      endcase
      s = a + y + ci;
      r = s[DW-1:0];
      c = s[DW];
      v = (a[DW-1] == y[DW-1]) && (r[DW-1] != a[DW-1]);
    end else if (fs[2] == 1'b0) begin
      case (fs[1:0])
        2'd0: r = a & b;
        2'd1: r = a | b;
        2'd2: r = a ^ b;
        default: r = ~a;
      endcase
    end else begin
      case (fs[1:0])
        2'd1: r = b >> 1;
        2'd2: r = b << 1;
        default: r = b;
      endcase
    end
    return {v, c, r};
  endfunction

  task automatic step(input logic [15:0] cw, input logic [DW-1:0] k, input logic [DW-1:0] d,
                      input string tag);
    exp_t          it;
    logic [DW+1:0] fu;
    logic [DW-1:0] res;
    @(negedge clk);
    ctrl = cw; kin = k; din = d;
    #2;
    it.a = model[cw[12:10]];
    it.b = cw[6] ? k : model[cw[9:7]];
    fu   = model_fu(cw[5:2], it.a, it.b);
    res  = fu[DW-1:0];
    it.vcnz = {fu[DW+1], fu[DW], res[DW-1], (res == '0)};
    it.tag  = tag;
    exp_q.push_back(it);
    if (cw[0]) model[cw[15:13]] = cw[1] ? d : res;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ctrl = '0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
  endtask

  // monitor
  initial begin
    exp_t it;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      checks++;
      if (addr_out !== it.a || data_out !== it.b || {fv, fc, fn, fz} !== it.vcnz) begin
        errors++;
        $display("FAIL %s: got a=%h b=%h vcnz=%b, expected a=%h b=%h vcnz=%b",
                 it.tag, addr_out, data_out, {fv, fc, fn, fz}, it.a, it.b, it.vcnz);
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R10: every register reads zero after reset
    for (int i = 0; i < 8; i++) step(mk(0, i, i, 0, 4'b0000, 0, 0), 8'h00, 8'h00, "R10");
    // R5: external write-back loads the file
    step(mk(2, 0, 0, 0, 4'b0000, 1, 1), 8'h00, 8'h7F, "R5");
    step(mk(3, 0, 0, 0, 4'b0000, 1, 1), 8'h00, 8'h01, "R5");
    step(mk(6, 0, 0, 0, 4'b0000, 1, 1), 8'h00, 8'h81, "R5");
    step(mk(5, 0, 0, 0, 4'b0000, 1, 1), 8'h00, 8'hFF, "R5");
    step(mk(7, 0, 0, 0, 4'b0000, 1, 1), 8'h00, 8'h05, "R5");
    // R1 R6: R1 <= R2 + R3 + 1, signed overflow into 0x81
    step(16'b001_010_011_0_0101_0_1, 8'h00, 8'h00, "R6");
    step(mk(0, 1, 2, 0, 4'b0000, 0, 0), 8'h00, 8'h00, "R3");
    // R8: R4 <= shl R6, then shr
    step(16'b100_010_110_0_1110_0_1, 8'h00, 8'h00, "R8");
    step(mk(0, 4, 6, 0, 4'b1101, 0, 0), 8'h00, 8'h00, "R8");
    step(mk(0, 4, 5, 0, 4'b1111, 0, 0), 8'h00, 8'h00, "R8");
    // R2: constant on Bus B
    step(mk(0, 2, 5, 1, 4'b0010, 0, 0), 8'h81, 8'h00, "R2");
    // R6 R9: carry out with zero result
    step(mk(0, 5, 3, 0, 4'b0010, 0, 0), 8'h00, 8'h00, "R9");
    // R6: subtraction with borrow, and decrement / pass-through carry
    step(mk(0, 7, 2, 0, 4'b0100, 0, 0), 8'h00, 8'h00, "R6");
    step(mk(0, 0, 2, 0, 4'b0110, 0, 0), 8'h00, 8'h00, "R6");
    step(mk(0, 2, 2, 0, 4'b0111, 0, 0), 8'h00, 8'h00, "R6");
    // R7: logic ops
    step(mk(0, 6, 7, 0, 4'b1000, 0, 0), 8'h00, 8'h00, "R7");
    step(mk(0, 6, 7, 0, 4'b1010, 0, 0), 8'h00, 8'h00, "R7");
    step(mk(0, 5, 7, 0, 4'b1011, 0, 0), 8'h00, 8'h00, "R7");
    // R11: read-during-write shows old value, new value next cycle
    step(mk(1, 1, 1, 0, 4'b0000, 1, 1), 8'h00, 8'h55, "R11");
    step(mk(0, 1, 1, 0, 4'b0000, 0, 0), 8'h00, 8'h00, "R11");
    // R4: write disabled, destination unchanged
    step(mk(3, 5, 5, 0, 4'b0010, 1, 0), 8'h00, 8'hAA, "R4");
    step(mk(0, 3, 3, 0, 4'b0000, 0, 0), 8'h00, 8'h00, "R4");
    // R1 R3 R5 R6 R7 R8 R9: random micro-operations
    for (int n = 0; n < 600; n++)
      step(16'($urandom), 8'($urandom), 8'($urandom), "R1");
    // R10: reset mid-run clears everything
    do_reset();
    for (int i = 0; i < 8; i++) step(mk(0, i, i, 0, 4'b0000, 0, 0), 8'h00, 8'h00, "R10");
    @(negedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule